// File: doc/BRIEF.md
# Peripheral Idle, Reset and Interrupt Control Slave

This block is the small memory-mapped control slave that sits beside a USB link-layer peripheral. Software uses it to pick how the peripheral answers an idle request from the system power controller, to kick off a timed software reset and poll for its end, and to learn when the functional clock it depends on must be started or may be stopped. Those clock events come from comparing the OR of the per-channel clock requests against a software-maintained "clock is stable" flag. A third event flags PHY-side accesses made while the USB clock is stopped.

Each event sets a sticky status bit. Writing a 1 to a status bit clears it. A per-bit enable lets the event reach one level-sensitive interrupt line. Reads are combinational from the current address. Writes take effect on the clock edge where request and write-enable are both high. The idle acknowledge is registered. The clock gating cells, wake-up signalling and context memory are outside the block; it only exports the configuration bits they need.

Top module: `usb_pm_regs`

## Requirements
- R1: After the reset input, configuration (0x10), interrupt status (0x18) and interrupt enable (0x1C) read 0, status (0x14) reads 1, and `irq` and `idle_ack` are low.
- R2: Configuration at 0x10 stores bit0 (autoidle), bit2 (wake-up enable), bits 4:3 (idle mode) and bit8 (clock activity). Every other bit reads 0, including bit1 (software reset). The stored bits appear on `autoidle_en`, `wakeup_en` and `clkact_en`.
- R3: Offset 0x04 reads `CTX_WORDS` in bits 7:0 and zero above. Any unmapped offset reads 0.
- R4: Idle mode 0 (force) sets `idle_ack` one cycle after `idle_req` is seen high. `idle_ack` drops one cycle after `idle_req` falls.
- R5: In idle mode 1 (no-idle), and in the unused code 3, `idle_ack` stays low.
- R6: Idle mode 2 (smart) sets `idle_ack` only in the cycle after a cycle with `idle_req` high and `bus_req` low.
- R7: Writing 0x10 with bit1 set starts a software reset. Status bit0 then reads 0 for exactly `RST_CYCLES` cycles, beginning the cycle after the write. During that time, configuration, enable and interrupt status are held at 0 and writes to them are ignored. Writing 0x10 with bit1 clear starts no reset.
- R8: Status bit0 (clock start) sets one cycle after the OR of `chan_clk_req` rises while 0x30 bit0 is 0.
- R9: Status bit1 (clock end) sets one cycle after the OR of `chan_clk_req` falls while 0x30 bit0 is 1.
- R10: Status bit2 (access error) sets one cycle after a cycle with `phy_access` high and `usb_clk_run` low.
- R11: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. An event in the same cycle as its clear leaves the bit set.
- R12: `irq` is high exactly when some status bit and the same enable bit (0x1C, same positions) are both 1.
- R13: At 0x30, bit0 is a software-written clock-stable flag, also driven on `fclk_stable`. Bit1 reads the live OR of `chan_clk_req`. A software reset does not touch bit0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| idle_req | input | 1 | Idle request from power controller |
| idle_ack | output | 1 | Idle acknowledge |
| chan_clk_req | input | NCHAN | Per-channel functional clock requests |
| phy_access | input | 1 | Software is accessing PHY-side registers |
| usb_clk_run | input | 1 | USB clock is running |
| autoidle_en | output | 1 | Configuration autoidle bit |
| wakeup_en | output | 1 | Configuration wake-up enable bit |
| clkact_en | output | 1 | Configuration clock activity bit |
| fclk_stable | output | 1 | Clock-stable flag from 0x30 bit0 |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the collision of an event with a write-1-to-clear in the same cycle. A design that lets the clear win loses interrupts, and the random phase catches that against its bench model. It times the software-reset window exactly: an off-by-one counter shows up as one too many or one too few zero reads of status bit0. It checks that writes made during the window do not land. For the smart idle mode it holds a bus access pending alongside the idle request, which catches a design that acknowledges early. Clock-start and clock-end are checked with the stable flag both right and wrong, so an edge detector with the wrong polarity or qualification raises spurious events.

// File: rtl/usb_pm_regs.sv
module usb_pm_regs #(
  parameter int ADDR_W     = 8,
  parameter int NCHAN      = 3,
  parameter int RST_CYCLES = 8,
  parameter int CTX_WORDS  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              idle_req,
  output logic              idle_ack,
  input  logic [NCHAN-1:0]  chan_clk_req,
  input  logic              phy_access,
  input  logic              usb_clk_run,
  output logic              autoidle_en,
  output logic              wakeup_en,
  output logic              clkact_en,
  output logic              fclk_stable,
  output logic              irq
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [ADDR_W-1:0] A_INFO = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_IRQS = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_IRQE = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_SHRD = ADDR_W'(8'h30);

  logic [CW-1:0] rst_cnt;
  logic [1:0]    idle_mode;
  logic [2:0]    irq_sts, irq_en, evt;
  logic          creq, creq_q, clk_on;

  wire wr       = bus_req & bus_we;
  wire wr_cfg   = wr && (bus_addr == A_CFG);
  wire sw_rst   = wr_cfg & bus_wdata[1];
  wire busy     = (rst_cnt != '0);
  wire hold     = sw_rst | busy;

  assign creq = |chan_clk_req;
  assign evt  = {phy_access & ~usb_clk_run,
                 ~creq & creq_q & clk_on,
                 creq & ~creq_q & ~clk_on};
  assign irq  = |(irq_sts & irq_en);
  assign fclk_stable = clk_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rst_cnt <= '0;
    else if (sw_rst) rst_cnt <= CW'(RST_CYCLES);
    else if (busy)   rst_cnt <= rst_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {clkact_en, idle_mode, wakeup_en, autoidle_en} <= '0;
      irq_en <= '0;
    end else if (hold) begin
      {clkact_en, idle_mode, wakeup_en, autoidle_en} <= '0;
      irq_en <= '0;
    end else begin
      if (wr_cfg)
        {clkact_en, idle_mode, wakeup_en, autoidle_en} <=
          {bus_wdata[8], bus_wdata[4:3], bus_wdata[2], bus_wdata[0]};
      if (wr && bus_addr == A_IRQE) irq_en <= bus_wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    irq_sts <= '0;
    else if (hold) irq_sts <= '0;
    else irq_sts <= (irq_sts & ~((wr && bus_addr == A_IRQS) ? bus_wdata[2:0] : 3'b0)) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_on <= 1'b0;
      creq_q <= 1'b0;
    end else begin
      creq_q <= creq;
      if (wr && bus_addr == A_SHRD) clk_on <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_ack <= 1'b0;
    else begin
      case (idle_mode)
        2'd0:    idle_ack <= idle_req;
        2'd2:    idle_ack <= idle_req & ~bus_req;
        default: idle_ack <= 1'b0;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_INFO: bus_rdata[7:0] = 8'(CTX_WORDS);
      A_CFG:  bus_rdata = {23'b0, clkact_en, 3'b0, idle_mode, wakeup_en, 1'b0, autoidle_en};
      A_STAT: bus_rdata[0] = ~busy;
      A_IRQS: bus_rdata[2:0] = irq_sts;
      A_IRQE: bus_rdata[2:0] = irq_en;
      A_SHRD: bus_rdata[1:0] = {creq, clk_on};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/usb_pm_regs_sva.sv
module usb_pm_regs_sva #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              idle_req,
  input logic              idle_ack,
  input logic              irq,
  input logic [1:0]        mode,
  input logic              busy,
  input logic [2:0]        sts
);
  a_r4_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ack |-> $past(idle_req));
  a_r5_noidle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd1) |-> !idle_ack);
  a_r6_smart_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_ack && $past(mode) == 2'd2) |-> !$past(bus_req));
  a_r7_reset_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_req && bus_we && bus_addr == ADDR_W'(8'h10) && bus_wdata[1]));
  a_r7_status_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (sts == 3'b0));
  a_r12_no_irq_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq);
endmodule

bind usb_pm_regs usb_pm_regs_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .idle_req(idle_req),
  .idle_ack(idle_ack), .irq(irq), .mode(idle_mode), .busy(busy), .sts(irq_sts)
);

// File: tb/usb_pm_regs_tb.sv
module usb_pm_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCHAN = 3;
  localparam int RSTC  = 8;
  localparam int CTXW  = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h18;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic idle_req = 1'b0, idle_ack;
  logic [NCHAN-1:0] chan_clk_req = '0;
  logic phy_access = 1'b0, usb_clk_run = 1'b1;
  logic autoidle_en, wakeup_en, clkact_en, fclk_stable, irq;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_pm_regs #(.ADDR_W(8), .NCHAN(NCHAN), .RST_CYCLES(RSTC), .CTX_WORDS(CTXW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .idle_req(idle_req), .idle_ack(idle_ack),
    .chan_clk_req(chan_clk_req), .phy_access(phy_access), .usb_clk_run(usb_clk_run),
    .autoidle_en(autoidle_en), .wakeup_en(wakeup_en), .clkact_en(clkact_en),
    .fclk_stable(fclk_stable), .irq(irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; bus_addr = 8'h18;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1 d = bus_rdata; bus_addr = 8'h18;
  endtask

  function automatic logic [2:0] events(input logic cr, input logic crp,
                                        input logic con, input logic pa, input logic ucr);
    return {pa & ~ucr, ~cr & crp & con, cr & ~crp & ~con};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [2:0] exp_sts, ev, mask;
    logic crp, con, cr;
    int low_cnt;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h10, d); check("R1 cfg reset", d, 0);
    rd(8'h14, d); check("R1 status reset", d, 1);
    rd(8'h18, d); check("R1 irq status reset", d, 0);
    rd(8'h1C, d); check("R1 enable reset", d, 0);
    check("R1 irq/ack low", {irq, idle_ack}, 0);
    rd(8'h04, d); check("R3 hwinfo", d, CTXW);
    rd(8'h08, d); check("R3 unmapped", d, 0);

    wr(8'h10, 32'hFFFF_FEFD);
    rd(8'h10, d); check("R2 cfg mask", d, 32'h0000_001D);
    check("R2 cfg pins", {clkact_en, wakeup_en, autoidle_en}, 3'b011);
    wr(8'h10, 32'h0000_0105);
    rd(8'h10, d); check("R2 cfg mode0 clkact", d, 32'h105);
    check("R2 clkact pin", clkact_en, 1);

    // R4 force idle
    @(negedge clk); idle_req = 1'b1; #1 check("R4 ack not yet", idle_ack, 0);
    @(negedge clk); check("R4 ack one cycle later", idle_ack, 1);
    idle_req = 1'b0;
    @(negedge clk); check("R4 ack drops", idle_ack, 0);

    // R5 no-idle and code 3
    wr(8'h10, 32'h08);
    idle_req = 1'b1;
    repeat (4) @(negedge clk);
    check("R5 no-idle", idle_ack, 0);
    wr(8'h10, 32'h18);
    repeat (3) @(negedge clk);
    check("R5 code3 no ack", idle_ack, 0);
    idle_req = 1'b0;

    // R6 smart idle with pending bus activity
    wr(8'h10, 32'h10);
    @(negedge clk); idle_req = 1'b1; bus_req = 1'b1; bus_we = 1'b0; bus_addr = 8'h04;
    repeat (3) @(negedge clk);
    check("R6 smart blocked by bus", idle_ack, 0);
    bus_req = 1'b0; bus_addr = 8'h18;
    @(negedge clk); check("R6 smart ack when quiet", idle_ack, 1);
    idle_req = 1'b0;
    @(negedge clk);

    // R13 shared register
    wr(8'h30, 32'h1);
    chan_clk_req = 3'b010; #1;
    rd(8'h30, d); check("R13 shared read", d, 32'h3);
    check("R13 fclk_stable", fclk_stable, 1);
    @(negedge clk);
    rd(8'h18, d); check("R8 no start when clock on", d, 0);
    chan_clk_req = '0;
    @(negedge clk);
    rd(8'h18, d); check("R9 clock end set", d, 32'h2);
    wr(8'h30, 32'h0);
    chan_clk_req = 3'b100;
    @(negedge clk);
    rd(8'h18, d); check("R8 clock start set", d, 32'h3);
    chan_clk_req = '0;
    @(negedge clk);
    rd(8'h18, d); check("R9 no end when clock off", d, 32'h3);
    phy_access = 1'b1; usb_clk_run = 1'b1;
    @(negedge clk); phy_access = 1'b0;
    rd(8'h18, d); check("R10 no error with clock running", d, 32'h3);
    phy_access = 1'b1; usb_clk_run = 1'b0;
    @(negedge clk); phy_access = 1'b0; usb_clk_run = 1'b1;
    rd(8'h18, d); check("R10 access error set", d, 32'h7);
    check("R12 irq masked", irq, 0);
    wr(8'h1C, 32'h4);
    check("R12 irq enabled", irq, 1);
    wr(8'h18, 32'h1);
    rd(8'h18, d); check("R11 w1c bit0", d, 32'h6);
    wr(8'h18, 32'h4);
    check("R12 irq off after clear", irq, 0);

    // R11 event wins over clear
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h1; chan_clk_req = 3'b001;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; bus_addr = 8'h18; chan_clk_req = '0;
    rd(8'h18, d); check("R11 event beats clear", d, 32'h3);

    // R7 software reset
    wr(8'h10, 32'h0);
    rd(8'h14, d); check("R7 zero write no reset", d, 1);
    wr(8'h1C, 32'h7);
    wr(8'h30, 32'h1);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h11F;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    low_cnt = 0;
    for (int i = 0; i < RSTC + 4; i++) begin
      rd(8'h14, d);
      if (d[0] == 1'b0) low_cnt++;
      if (i == 2) begin
        rd(8'h10, d); check("R7 cfg held", d, 0);
        rd(8'h18, d); check("R7 status held", d, 0);
        check("R7 irq low", irq, 0);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 8'h1C; bus_wdata = 32'h7;
      end else begin
        bus_req = 1'b0; bus_we = 1'b0;
      end
      @(negedge clk);
    end
    bus_req = 1'b0; bus_we = 1'b0; bus_addr = 8'h18;
    check("R7 reset window length", low_cnt, RSTC);
    rd(8'h1C, d); check("R7 write during reset ignored", d, 0);
    rd(8'h30, d); check("R13 clock flag survives reset", d, 32'h1);

    // random phase: R8 R9 R10 R11 R12 against bench model
    wr(8'h1C, 32'h7);
    wr(8'h18, 32'h7);
    exp_sts = 3'b0; crp = 1'b0; con = 1'b1;
    for (int it = 0; it < 400; it++) begin
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0; bus_addr = 8'h18;
      #1;
      check("R11 random status", {29'b0, bus_rdata[2:0]}, {29'b0, exp_sts});
      check("R12 random irq", irq, |exp_sts);
      chan_clk_req = NCHAN'($urandom % 2 == 0 ? 0 : $urandom);
      phy_access = ($urandom % 4 == 0);
      usb_clk_run = $urandom;
      mask = 3'b0;
      if (it % 60 == 30) begin
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 8'h30; bus_wdata = {31'b0, ~con};
      end else if ($urandom % 5 == 0) begin
        mask = 3'($urandom);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 8'h18; bus_wdata = {29'b0, mask};
      end
      cr = |chan_clk_req;
      ev = events(cr, crp, con, phy_access, usb_clk_run);
      exp_sts = (exp_sts & ~mask) | ev;
      crp = cr;
      if (it % 60 == 30) con = ~con;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule